// File: doc/BRIEF.md
# MMU Fault Status Capture Registers

This block records diagnostic state about address-translation faults so that a fault handler can inspect it afterwards. The data side and the instruction side each have their own strobe. When the data-side strobe is high on a clock edge, the block can capture three things. The first is the faulting virtual address. The second is a packed memory-status word built from the faulting instruction's opcode, its destination-register number and the 6-bit access-flag field. The third is a formatted page-table-entry address. When the instruction-side strobe is high, the block captures the faulting fetch PC as an instruction tag, together with a formatted page-table-entry address for that PC.

A formatted address is a page-table base register ORed with the virtual page number shifted left by 3. Pages are 8 KiB, so the virtual page number is address bits 42:13 of the default 43-bit address. Software writes the two base registers through a simple write port. The data-side capture is dropped for misspeculated accesses, page-table-entry loads and no-fault requests. The instruction-side capture is dropped for misspeculated fetches. A dropped capture leaves the previously latched state unchanged. Every captured register is a plain output that can be read directly.

Top module: `mmu_fault_capture`

## Requirements
- R1: While `rst_n` is low, every capture register and both page-table base registers read zero.
- R2: On a clock edge where `d_fault` is high and `d_misspec`, `d_pte_load` and `d_no_fault` are all low, `va_q` takes `d_va`. The new value is visible after that edge.
- R3: On the same qualifying edge, `mmstat_q` takes the following packed value: bits 16:11 = `d_opcode`, bits 10:6 = `d_dest`, bits 5:0 = `d_flags`.
- R4: On the same qualifying edge, `dfmt_q` takes `dbase_q | (d_va[42:13] << 3)`. The value of `dbase_q` used is the one held before that edge.
- R5: On an edge where `d_fault` is high and any of `d_misspec`, `d_pte_load` or `d_no_fault` is high, `va_q`, `mmstat_q` and `dfmt_q` do not change.
- R6: On an edge where `i_fault` is high and `i_misspec` is low, `itag_q` takes `i_pc`. When `i_misspec` is high, `itag_q` and `ifmt_q` do not change.
- R7: On that qualifying instruction-side edge, `ifmt_q` takes `ibase_q | (i_pc[42:13] << 3)`. The value of `ibase_q` used is the one held before that edge.
- R8: When a side's strobe is low, that side's capture registers hold their values.
- R9: A data fault and an instruction fault strobed on the same edge each update their own register group, independently of the other.
- R10: When `base_we` is high, `base_wdata` is written to the data base (`base_sel` = 0) or to the instruction base (`base_sel` = 1). The write takes effect after the edge. Formatted addresses that were already captured are not changed by a later base write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| d_fault | input | 1 | Data-side fault strobe |
| d_va | input | 43 | Faulting data virtual address |
| d_flags | input | 6 | Access-flag field |
| d_opcode | input | 6 | Opcode of faulting instruction |
| d_dest | input | 5 | Destination register number |
| d_pte_load | input | 1 | Access is a page-table-entry load |
| d_no_fault | input | 1 | Access is marked no-fault |
| d_misspec | input | 1 | Data access is misspeculated |
| i_fault | input | 1 | Instruction-side fault strobe |
| i_pc | input | 43 | Faulting fetch PC |
| i_misspec | input | 1 | Fetch is misspeculated |
| base_we | input | 1 | Base register write enable |
| base_sel | input | 1 | 0 selects the data base, 1 selects the instruction base |
| base_wdata | input | 64 | Base register write data |
| va_q | output | 43 | Captured data virtual address |
| mmstat_q | output | 17 | Captured memory-status word |
| dfmt_q | output | 64 | Captured data formatted address |
| itag_q | output | 43 | Captured instruction tag |
| ifmt_q | output | 64 | Captured instruction formatted address |
| dbase_q | output | 64 | Data page-table base |
| ibase_q | output | 64 | Instruction page-table base |

## Verification
A wrong qualification term shows up one edge after the strobe. Either a suppressed access overwrites `va_q`, `mmstat_q` or `dfmt_q`, or a genuine fault leaves them stale. A misplaced field in the status packing, or a wrong page-number slice or shift, gives a wrong captured value on the first qualifying fault. A formatted address built from the base register's next value instead of its current one shows up only when a base write and a fault fall on the same edge, so the sweep deliberately makes those coincide. The same applies to a cross-coupled strobe between the two sides.

// File: rtl/mfc_pkg.sv
package mfc_pkg;

    parameter int DEF_VA_W     = 43;
    parameter int DEF_ADDR_W   = 64;
    parameter int DEF_PG_SHIFT = 13;
    parameter int DEF_OPC_W    = 6;
    parameter int DEF_REG_W    = 5;
    parameter int DEF_FLAG_W   = 6;
    parameter int PTE_SHIFT    = 3;

    typedef enum logic {
        BASE_DATA  = 1'b0,
        BASE_INSTR = 1'b1
    } base_sel_e;

endpackage

// File: rtl/mfc_base_regs.sv
module mfc_base_regs
    import mfc_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              sel,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] dbase,
    output logic [ADDR_W-1:0] ibase
);

    base_sel_e target;
    assign target = base_sel_e'(sel);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbase <= '0;
            ibase <= '0;
        end else if (we) begin
            unique case (target)
                BASE_DATA:  dbase <= wdata;
                BASE_INSTR: ibase <= wdata;
            endcase
        end
    end

endmodule

// File: rtl/mfc_fmt_addr.sv
module mfc_fmt_addr
    import mfc_pkg::*;
#(
    parameter int VA_W     = DEF_VA_W,
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int PG_SHIFT = DEF_PG_SHIFT
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [VA_W-1:0]   va,
    output logic [ADDR_W-1:0] fmt
);

    localparam int VPN_W = VA_W - PG_SHIFT;

    logic [VPN_W-1:0]  vpn;
    logic [ADDR_W-1:0] vpn_ext;

    assign vpn     = va[VA_W-1:PG_SHIFT];
    assign vpn_ext = ADDR_W'(vpn);
    assign fmt     = base | (vpn_ext << PTE_SHIFT);

endmodule

// File: rtl/mfc_dside.sv
module mfc_dside
    import mfc_pkg::*;
#(
    parameter int VA_W   = DEF_VA_W,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int OPC_W  = DEF_OPC_W,
    parameter int REG_W  = DEF_REG_W,
    parameter int FLAG_W = DEF_FLAG_W,
    localparam int ST_W  = OPC_W + REG_W + FLAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              misspec,
    input  logic              pte_load,
    input  logic              no_fault,
    input  logic [VA_W-1:0]   va,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [REG_W-1:0]  dest,
    input  logic [FLAG_W-1:0] flags,
    input  logic [ADDR_W-1:0] fmt_in,
    output logic [VA_W-1:0]   va_q,
    output logic [ST_W-1:0]   stat_q,
    output logic [ADDR_W-1:0] fmt_q
);

    logic take;
    assign take = strobe && !(misspec || pte_load || no_fault);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q   <= '0;
            stat_q <= '0;
            fmt_q  <= '0;
        end else if (take) begin
            va_q   <= va;
            stat_q <= {opcode, dest, flags};
            fmt_q  <= fmt_in;
        end
    end

endmodule

// File: rtl/mfc_iside.sv
module mfc_iside
    import mfc_pkg::*;
#(
    parameter int VA_W   = DEF_VA_W,
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              misspec,
    input  logic [VA_W-1:0]   pc,
    input  logic [ADDR_W-1:0] fmt_in,
    output logic [VA_W-1:0]   tag_q,
    output logic [ADDR_W-1:0] fmt_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q <= '0;
            fmt_q <= '0;
        end else if (strobe && !misspec) begin
            tag_q <= pc;
            fmt_q <= fmt_in;
        end
    end

endmodule

// File: rtl/mmu_fault_capture.sv
module mmu_fault_capture
    import mfc_pkg::*;
#(
    parameter int VA_W     = DEF_VA_W,
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int PG_SHIFT = DEF_PG_SHIFT,
    parameter int OPC_W    = DEF_OPC_W,
    parameter int REG_W    = DEF_REG_W,
    parameter int FLAG_W   = DEF_FLAG_W,
    localparam int ST_W    = OPC_W + REG_W + FLAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              d_fault,
    input  logic [VA_W-1:0]   d_va,
    input  logic [FLAG_W-1:0] d_flags,
    input  logic [OPC_W-1:0]  d_opcode,
    input  logic [REG_W-1:0]  d_dest,
    input  logic              d_pte_load,
    input  logic              d_no_fault,
    input  logic              d_misspec,
    input  logic              i_fault,
    input  logic [VA_W-1:0]   i_pc,
    input  logic              i_misspec,
    input  logic              base_we,
    input  logic              base_sel,
    input  logic [ADDR_W-1:0] base_wdata,
    output logic [VA_W-1:0]   va_q,
    output logic [ST_W-1:0]   mmstat_q,
    output logic [ADDR_W-1:0] dfmt_q,
    output logic [VA_W-1:0]   itag_q,
    output logic [ADDR_W-1:0] ifmt_q,
    output logic [ADDR_W-1:0] dbase_q,
    output logic [ADDR_W-1:0] ibase_q
);

    logic [ADDR_W-1:0] dfmt_next;
    logic [ADDR_W-1:0] ifmt_next;

    mfc_base_regs #(.ADDR_W(ADDR_W)) u_base (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (base_we),
        .sel   (base_sel),
        .wdata (base_wdata),
        .dbase (dbase_q),
        .ibase (ibase_q)
    );

    mfc_fmt_addr #(.VA_W(VA_W), .ADDR_W(ADDR_W), .PG_SHIFT(PG_SHIFT)) u_dfmt (
        .base (dbase_q),
        .va   (d_va),
        .fmt  (dfmt_next)
    );

    mfc_fmt_addr #(.VA_W(VA_W), .ADDR_W(ADDR_W), .PG_SHIFT(PG_SHIFT)) u_ifmt (
        .base (ibase_q),
        .va   (i_pc),
        .fmt  (ifmt_next)
    );

    mfc_dside #(
        .VA_W(VA_W), .ADDR_W(ADDR_W), .OPC_W(OPC_W), .REG_W(REG_W), .FLAG_W(FLAG_W)
    ) u_dside (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (d_fault),
        .misspec  (d_misspec),
        .pte_load (d_pte_load),
        .no_fault (d_no_fault),
        .va       (d_va),
        .opcode   (d_opcode),
        .dest     (d_dest),
        .flags    (d_flags),
        .fmt_in   (dfmt_next),
        .va_q     (va_q),
        .stat_q   (mmstat_q),
        .fmt_q    (dfmt_q)
    );

    mfc_iside #(.VA_W(VA_W), .ADDR_W(ADDR_W)) u_iside (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (i_fault),
        .misspec (i_misspec),
        .pc      (i_pc),
        .fmt_in  (ifmt_next),
        .tag_q   (itag_q),
        .fmt_q   (ifmt_q)
    );

endmodule

// File: rtl/mmu_fault_capture_chk.sv
module mmu_fault_capture_chk
    import mfc_pkg::*;
#(
    parameter int VA_W     = DEF_VA_W,
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int PG_SHIFT = DEF_PG_SHIFT,
    parameter int OPC_W    = DEF_OPC_W,
    parameter int REG_W    = DEF_REG_W,
    parameter int FLAG_W   = DEF_FLAG_W,
    localparam int ST_W    = OPC_W + REG_W + FLAG_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              d_fault,
    input logic [VA_W-1:0]   d_va,
    input logic [FLAG_W-1:0] d_flags,
    input logic [OPC_W-1:0]  d_opcode,
    input logic [REG_W-1:0]  d_dest,
    input logic              d_pte_load,
    input logic              d_no_fault,
    input logic              d_misspec,
    input logic              i_fault,
    input logic [VA_W-1:0]   i_pc,
    input logic              i_misspec,
    input logic              base_we,
    input logic              base_sel,
    input logic [ADDR_W-1:0] base_wdata,
    input logic [VA_W-1:0]   va_q,
    input logic [ST_W-1:0]   mmstat_q,
    input logic [ADDR_W-1:0] dfmt_q,
    input logic [VA_W-1:0]   itag_q,
    input logic [ADDR_W-1:0] ifmt_q,
    input logic [ADDR_W-1:0] dbase_q,
    input logic [ADDR_W-1:0] ibase_q
);

    logic d_ok, d_drop, i_ok;
    assign d_ok   = d_fault && !d_misspec && !d_pte_load && !d_no_fault;
    assign d_drop = d_fault && (d_misspec || d_pte_load || d_no_fault);
    assign i_ok   = i_fault && !i_misspec;

    p_va_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        d_ok |=> va_q == $past(d_va));

    p_status_pack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        d_ok |=> mmstat_q == {$past(d_opcode), $past(d_dest), $past(d_flags)});

    p_dfmt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        d_ok |=> dfmt_q == ($past(dbase_q)
                 | (ADDR_W'($past(d_va[VA_W-1:PG_SHIFT])) << PTE_SHIFT)));

    p_suppress_r5: assert property (@(posedge clk) disable iff (!rst_n)
        d_drop |=> $stable(va_q) && $stable(mmstat_q) && $stable(dfmt_q));

    p_itag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        i_ok |=> itag_q == $past(i_pc));

    p_ispec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (i_fault && i_misspec) |=> $stable(itag_q) && $stable(ifmt_q));

    p_ifmt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        i_ok |=> ifmt_q == ($past(ibase_q)
                 | (ADDR_W'($past(i_pc[VA_W-1:PG_SHIFT])) << PTE_SHIFT)));

    p_dhold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !d_fault |=> $stable(va_q) && $stable(mmstat_q) && $stable(dfmt_q));

    p_ihold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !i_fault |=> $stable(itag_q) && $stable(ifmt_q));

    p_dbase_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (base_we && !base_sel) |=> dbase_q == $past(base_wdata));

    p_ibase_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (base_we && base_sel) |=> ibase_q == $past(base_wdata));

endmodule

bind mmu_fault_capture mmu_fault_capture_chk #(
    .VA_W(VA_W), .ADDR_W(ADDR_W), .PG_SHIFT(PG_SHIFT),
    .OPC_W(OPC_W), .REG_W(REG_W), .FLAG_W(FLAG_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .d_fault(d_fault), .d_va(d_va), .d_flags(d_flags),
    .d_opcode(d_opcode), .d_dest(d_dest), .d_pte_load(d_pte_load),
    .d_no_fault(d_no_fault), .d_misspec(d_misspec), .i_fault(i_fault),
    .i_pc(i_pc), .i_misspec(i_misspec), .base_we(base_we), .base_sel(base_sel),
    .base_wdata(base_wdata), .va_q(va_q), .mmstat_q(mmstat_q), .dfmt_q(dfmt_q),
    .itag_q(itag_q), .ifmt_q(ifmt_q), .dbase_q(dbase_q), .ibase_q(ibase_q)
);

// File: tb/sim_mmu_fault_capture.sv
module sim_mmu_fault_capture;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        d_fault = 1'b0;
    logic [42:0] d_va = '0;
    logic [5:0]  d_flags = '0;
    logic [5:0]  d_opcode = '0;
    logic [4:0]  d_dest = '0;
    logic        d_pte_load = 1'b0;
    logic        d_no_fault = 1'b0;
    logic        d_misspec = 1'b0;
    logic        i_fault = 1'b0;
    logic [42:0] i_pc = '0;
    logic        i_misspec = 1'b0;
    logic        base_we = 1'b0;
    logic        base_sel = 1'b0;
    logic [63:0] base_wdata = '0;
    logic [42:0] va_q;
    logic [16:0] mmstat_q;
    logic [63:0] dfmt_q;
    logic [42:0] itag_q;
    logic [63:0] ifmt_q;
    logic [63:0] dbase_q;
    logic [63:0] ibase_q;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    logic [42:0] m_va = '0, m_itag = '0;
    logic [16:0] m_stat = '0;
    logic [63:0] m_dfmt = '0, m_ifmt = '0, m_dbase = '0, m_ibase = '0;

    always #5 clk = ~clk;

    mmu_fault_capture u0 (.*);

    function automatic logic [63:0] fmt_of(logic [63:0] base, logic [42:0] a);
        logic [63:0] vpn;
        vpn = 64'(a >> 13);
        return base | (vpn * 64'd8);
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        logic        dq, iq, both;
        logic [42:0] n_va, n_itag;
        logic [16:0] n_stat;
        logic [63:0] n_dfmt, n_ifmt, n_db, n_ib;
        string       dl, il;
        dq = d_fault && !d_misspec && !d_pte_load && !d_no_fault;
        iq = i_fault && !i_misspec;
        both = d_fault && i_fault;
        n_va = m_va; n_stat = m_stat; n_dfmt = m_dfmt;
        n_itag = m_itag; n_ifmt = m_ifmt; n_db = m_dbase; n_ib = m_ibase;
        if (dq) begin
            n_va = d_va;
            n_stat = 17'(d_opcode) * 17'd2048 + 17'(d_dest) * 17'd64 + 17'(d_flags);
            n_dfmt = fmt_of(m_dbase, d_va);
        end
        if (iq) begin
            n_itag = i_pc;
            n_ifmt = fmt_of(m_ibase, i_pc);
        end
        if (base_we) begin
            if (base_sel) n_ib = base_wdata;
            else          n_db = base_wdata;
        end
        dl = !d_fault ? "R8" : (dq ? (both ? "R9" : "R2") : "R5");
        il = !i_fault ? "R8" : (both ? "R9" : "R6");
        @(posedge clk);
        #2;
        m_va = n_va; m_stat = n_stat; m_dfmt = n_dfmt;
        m_itag = n_itag; m_ifmt = n_ifmt; m_dbase = n_db; m_ibase = n_ib;
        chk(dl, 64'(va_q), 64'(m_va));
        chk(dq ? "R3" : dl, 64'(mmstat_q), 64'(m_stat));
        chk(dq ? "R4" : dl, dfmt_q, m_dfmt);
        chk(il, 64'(itag_q), 64'(m_itag));
        chk(iq ? "R7" : il, ifmt_q, m_ifmt);
        chk("R10", dbase_q, m_dbase);
        chk("R10", ibase_q, m_ibase);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state of every register
        chk("R1", 64'(va_q), 0);
        chk("R1", 64'(mmstat_q), 0);
        chk("R1", dfmt_q, 0);
        chk("R1", 64'(itag_q), 0);
        chk("R1", ifmt_q, 0);
        chk("R1", dbase_q, 0);
        chk("R1", ibase_q, 0);
        rst_n = 1'b1;

        // R10: load both bases, then boundary capture with all-ones address
        base_we = 1; base_sel = 0; base_wdata = 64'hFFFF_0000_0000_0005;
        tick();
        base_sel = 1; base_wdata = 64'h0000_0000_0000_0003;
        tick();
        base_we = 0;
        d_fault = 1; d_va = '1; d_opcode = '1; d_dest = '1; d_flags = '1;
        i_fault = 1; i_pc = '1;
        tick();
        d_fault = 0; i_fault = 0;
        // R10: base write after capture leaves captured addresses unchanged
        base_we = 1; base_sel = 0; base_wdata = 64'h1234;
        tick();
        base_we = 0;
        tick();

        // Sweep: attribute combinations, strobes, coinciding base writes
        for (int i = 0; i < 256; i++) begin
            logic [63:0] h;
            h = 64'(i + 1) * 64'h9E37_79B9_7F4A_7C15;
            d_fault    = (i % 5) != 4;
            d_misspec  = i[0];
            d_pte_load = i[1];
            d_no_fault = i[2];
            i_fault    = i[3] | i[6];
            i_misspec  = i[4] & i[5];
            d_va       = h[42:0];
            i_pc       = h[63:21];
            d_opcode   = h[5:0] ^ 6'(i);
            d_dest     = h[12:8];
            d_flags    = h[19:14];
            base_we    = (i % 7) == 0;
            base_sel   = i[5];
            base_wdata = {h[31:0], h[63:32]};
            tick();
        end
        d_fault = 0; i_fault = 0; base_we = 0;
        tick();
        finish_run();
    end

endmodule